// File: doc/BRIEF.md
# Asynchronous Static RAM Controller with Byte Lanes

This block sits between a clocked host request port and an external asynchronous static RAM of 64K words by 16 bits. The host presents one request at a time (address, read or write, write data and a per-byte mask) with a valid/ready handshake. The controller turns each request into a sequence of memory strobes: active-low chip enable, output enable and write enable, plus one active-low select per byte lane. Every interval in that sequence is a whole number of clock cycles set by a parameter. Each parameter is the nanosecond minimum divided by the clock period, rounded up.

Reads hold the access for a programmed number of cycles and capture the returned word into a register. The captured word comes back with a one-cycle valid pulse, with unselected lanes forced to zero. Writes first hold output enable high with the bus released, for a lead time. The controller then drives the data bus and pulses the lane selects while write enable is low. When writes arrive back to back, write enable stays low and only the lane selects frame each word. Before chip enable rises or a read begins, the bus is released for one cycle with chip enable still low.

Top module: `sramc_top`

## Requirements
- R1: During and after reset, all memory strobes (chip, output and write enable, both lane selects) are high, the bus is not driven, `reqReady` is 1 and `rspValid` is 0.
- R2: An accepted read holds chip enable and output enable low, write enable high and the request address on `memAddr`, for exactly RD_CYC cycles. During those cycles the lane select of byte lane i is low exactly when mask bit i is 1. Bit 0 is the lower lane (data bits 7..0) and bit 1 is the upper lane (bits 15..8).
- R3: On the last access cycle the read word is captured. It is returned on `rspData` with `rspValid` high for exactly one cycle, in the cycle after the access. A lane whose mask bit is 0 returns zero.
- R4: An accepted write from idle first spends LEAD_CYC cycles with chip enable low, output and write enable high, lane selects high and the bus undriven.
- R5: Each write word then has PULSE_CYC cycles with write enable low, the masked lane selects low, and the bus driven with the write data at the request address.
- R6: The bus is driven only while chip enable is low and output enable is high. Output enable is never low while write enable is low.
- R7: After each pulse, one hold cycle follows with write enable still low, all lane selects high and the data still driven. A write accepted during that cycle starts its pulse at once without raising write enable.
- R8: When no further write follows a hold cycle, one turnaround cycle has chip enable low, write enable high and the bus released. A read accepted in the hold cycle starts its access after this turnaround.
- R9: `reqReady` is 1 only when idle or in a write hold cycle. Request fields are captured on a clock edge where `reqValid` and `reqReady` are both 1.
- R10: A write with mask 00 passes through the same phases with both lane selects high throughout, so memory contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Byte-lane enables, bit 0 = bits 7..0 |
| rspValid | output | 1 | One-cycle read data valid |
| rspData | output | 16 | Read data, unselected lanes zero |
| memAddr | output | 16 | Memory address |
| memCeN | output | 1 | Memory chip enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memLaneN | output | 2 | Lane selects, active low, bit 0 lower byte |
| memDout | output | 16 | Data driven toward memory |
| memDoe | output | 1 | Drive enable for memDout |
| memDin | input | 16 | Data sampled from memory |

## Verification
The bound checker watches the bus-ownership and strobe-ordering rules on every cycle. It checks that the bus is driven only while chip enable is low and output enable is high. It checks that output enable is high and the bus released before write enable falls, and that the bus is released the cycle before chip enable rises. It also checks that lanes never pulse without the bus driven, that the address is stable across a lane pulse, and that the response valid is a single-cycle pulse. The exact phase lengths, the lane-select pattern for each mask, and back-to-back framing need the bench's scheduled expectations. So do the returned read data with zeroed lanes and the memory left untouched by an empty-mask write.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_WLEAD,
    S_WPULSE,
    S_WHOLD,
    S_TURN,
    S_TURNRD
  } state_t;

  // strobes from control to datapath and pins
  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic laneOn;   // lane selects follow the captured mask
    logic busOn;    // drive write data
    logic capture;  // latch read data at this edge
    logic accept;   // latch request fields at this edge
  } strobe_t;

endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int RD_CYC    = 2,
  parameter int LEAD_CYC  = 1,
  parameter int PULSE_CYC = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t stb
);

  localparam int MAX_AB = (RD_CYC > LEAD_CYC) ? RD_CYC : LEAD_CYC;
  localparam int MAX_C  = (MAX_AB > PULSE_CYC) ? MAX_AB : PULSE_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  localparam logic [CNT_W-1:0] RD_LOAD    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LEAD_LOAD  = CNT_W'(LEAD_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYC - 1);

  state_t state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic accept, lastCyc;

  assign reqReady = (state == S_IDLE) || (state == S_WHOLD);
  assign accept   = reqValid && reqReady;
  assign lastCyc  = (cnt == '0);

  always_comb begin
    nState = state;
    nCnt   = lastCyc ? cnt : cnt - 1'b1;
    unique case (state)
      S_IDLE: if (accept) begin
        nState = reqWrite ? S_WLEAD : S_RD;
        nCnt   = reqWrite ? LEAD_LOAD : RD_LOAD;
      end
      S_RD:     if (lastCyc) nState = S_IDLE;
      S_WLEAD:  if (lastCyc) begin
        nState = S_WPULSE;
        nCnt   = PULSE_LOAD;
      end
      S_WPULSE: if (lastCyc) nState = S_WHOLD;
      S_WHOLD: begin
        if (accept && reqWrite) begin
          nState = S_WPULSE;
          nCnt   = PULSE_LOAD;
        end else if (accept) begin
          nState = S_TURNRD;
        end else begin
          nState = S_TURN;
        end
      end
      S_TURN:   nState = S_IDLE;
      S_TURNRD: begin
        nState = S_RD;
        nCnt   = RD_LOAD;
      end
      default:  nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nState;
      cnt   <= nCnt;
    end
  end

  always_comb begin
    stb.ceN     = (state == S_IDLE);
    stb.oeN     = (state != S_RD);
    stb.weN     = !((state == S_WPULSE) || (state == S_WHOLD));
    stb.laneOn  = (state == S_RD) || (state == S_WPULSE);
    stb.busOn   = (state == S_WPULSE) || (state == S_WHOLD);
    stb.capture = (state == S_RD) && lastCyc;
    stb.accept  = accept;
  end

endmodule

// File: rtl/sramc_dp.sv
module sramc_dp
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic [LANES-1:0]  memLaneN,
  output logic [DATA_W-1:0] rspData,
  output logic              rspValid
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else if (stb.accept) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
      maskQ <= reqMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= stb.capture;
  end

  for (genvar i = 0; i < LANES; i++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rspData[i*LANE_W +: LANE_W] <= '0;
      else if (stb.capture)
        rspData[i*LANE_W +: LANE_W] <= maskQ[i] ? memDin[i*LANE_W +: LANE_W] : '0;
    end
    assign memLaneN[i] = !(stb.laneOn && maskQ[i]);
  end

  assign memAddr = addrQ;
  assign memDout = dataQ;

endmodule

// File: rtl/sramc_top.sv
module sramc_top
  import sramc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int LANES     = 2,
  parameter int RD_CYC    = 2,
  parameter int LEAD_CYC  = 1,
  parameter int PULSE_CYC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [LANES-1:0]  memLaneN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  input  logic [DATA_W-1:0] memDin
);

  strobe_t stb;

  sramc_ctrl #(
    .RD_CYC(RD_CYC), .LEAD_CYC(LEAD_CYC), .PULSE_CYC(PULSE_CYC)
  ) ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .stb(stb)
  );

  sramc_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqMask(reqMask), .memDin(memDin),
    .memAddr(memAddr), .memDout(memDout), .memLaneN(memLaneN),
    .rspData(rspData), .rspValid(rspValid)
  );

  assign memCeN = stb.ceN;
  assign memOeN = stb.oeN;
  assign memWeN = stb.weN;
  assign memDoe = stb.busOn;

endmodule

// File: rtl/sramc_chk.sv
module sramc_chk #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic [LANES-1:0]  memLaneN,
  input logic              memDoe
);

  // R6
  bus_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDoe |-> (!memCeN && memOeN));

  // R6
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  // R4
  oe_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> ($past(memOeN) && !$past(memCeN) && !$past(memDoe)));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCeN) |-> !$past(memDoe));

  // R2
  read_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memCeN && !memDoe));

  // R5
  lane_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && (memLaneN != '1)) |-> memDoe);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN) && (memLaneN != '1) && ($past(memLaneN) != '1))
      |-> $stable(memAddr));

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN || (memWeN && !memCeN)) |-> !reqReady);

endmodule

bind sramc_top sramc_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
  .memLaneN(memLaneN), .memDoe(memDoe)
);

// File: tb/sramc_top_test.sv
module sramc_top_test;

  localparam int RDC = 3;
  localparam int LDC = 2;
  localparam int PLC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0;
  logic [1:0] reqMask = '0;
  logic reqReady, rspValid, memCeN, memOeN, memWeN, memDoe;
  logic [15:0] rspData, memAddr, memDout, memDin;
  logic [1:0] memLaneN;

  always #5 clk = ~clk;

  sramc_top #(.RD_CYC(RDC), .LEAD_CYC(LDC), .PULSE_CYC(PLC)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqMask(reqMask), .rspValid(rspValid), .rspData(rspData),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memLaneN(memLaneN), .memDout(memDout), .memDoe(memDoe), .memDin(memDin)
  );

  // behavioural memory
  logic [15:0] mem [256];
  logic [15:0] shadow [256];
  initial for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end

  always @(posedge clk)
    if (!memCeN && !memWeN && memDoe) begin
      if (!memLaneN[0]) mem[memAddr[7:0]][7:0]  <= memDout[7:0];
      if (!memLaneN[1]) mem[memAddr[7:0]][15:8] <= memDout[15:8];
    end

  wire rdOn = !memCeN && !memOeN && memWeN;
  assign memDin = {(rdOn && !memLaneN[1]) ? mem[memAddr[7:0]][15:8] : 8'hEE,
                   (rdOn && !memLaneN[0]) ? mem[memAddr[7:0]][7:0]  : 8'hEE};

  typedef struct {
    logic ceN, oeN, weN;
    logic [1:0] laneN;
    logic doe, rdy, rv;
    bit chkA;
    logic [15:0] a;
    bit chkD;
    logic [15:0] d;
    string tag;
  } exp_t;

  exp_t expQ[$];
  logic [15:0] rdQ[$];
  int checks = 0, fails = 0;
  bit monOn = 0;

  function automatic exp_t mk(logic ce, logic oe, logic we, logic [1:0] ln,
      logic doe, logic rdy, logic rv, bit ca, logic [15:0] a, bit cd,
      logic [15:0] d, string tag);
    exp_t e;
    e.ceN = ce; e.oeN = oe; e.weN = we; e.laneN = ln; e.doe = doe;
    e.rdy = rdy; e.rv = rv; e.chkA = ca; e.a = a; e.chkD = cd; e.d = d;
    e.tag = tag;
    return e;
  endfunction

  // idle/ready expectation covers R9
  function automatic exp_t idleE(logic rv, string tag);
    return mk(1, 1, 1, 2'b11, 0, 1, rv, 0, '0, 0, '0, tag);
  endfunction

  task automatic cmpPins(exp_t e);
    bit bad;
    checks++;
    bad = (memCeN !== e.ceN) || (memOeN !== e.oeN) || (memWeN !== e.weN) ||
          (memLaneN !== e.laneN) || (memDoe !== e.doe) ||
          (reqReady !== e.rdy) || (rspValid !== e.rv) ||
          (e.chkA && memAddr !== e.a) || (e.chkD && memDout !== e.d);
    if (bad) begin
      fails++;
      $display("FAIL %s: got ce=%b oe=%b we=%b ln=%b doe=%b rdy=%b rv=%b a=%h d=%h; expected ce=%b oe=%b we=%b ln=%b doe=%b rdy=%b rv=%b a=%h d=%h",
        e.tag, memCeN, memOeN, memWeN, memLaneN, memDoe, reqReady, rspValid,
        memAddr, memDout, e.ceN, e.oeN, e.weN, e.laneN, e.doe, e.rdy, e.rv,
        e.a, e.d);
    end
  endtask

  // cycle-by-cycle comparison against the expectation queue
  always @(negedge clk) if (monOn) begin
    exp_t e;
    e = (expQ.size() != 0) ? expQ.pop_front() : idleE(0, "R9");
    cmpPins(e);
    if (rspValid) begin
      logic [15:0] x;
      x = (rdQ.size() != 0) ? rdQ.pop_front() : 16'hxxxx;
      checks++;
      if (rspData !== x) begin
        fails++;
        $display("FAIL R3: rspData got %h expected %h", rspData, x);
      end
    end
  end

  function automatic logic [15:0] laneMerge(logic [15:0] old, logic [15:0] nw,
                                            logic [1:0] m);
    return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
  endfunction

  function automatic logic [15:0] rdExpect(logic [15:0] a, logic [1:0] m);
    return laneMerge(16'h0000, shadow[a[7:0]], m);
  endfunction

  task automatic pushRead(logic [15:0] a, logic [1:0] m);
    for (int i = 0; i < RDC; i++)
      expQ.push_back(mk(0, 0, 1, ~m, 0, 0, 0, 1, a, 0, '0, "R2"));
    expQ.push_back(idleE(1, "R3"));
    rdQ.push_back(rdExpect(a, m));
  endtask

  task automatic drainQ();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic readOp(logic [15:0] a, logic [1:0] m);
    @(negedge clk); #2;
    reqValid = 1; reqWrite = 0; reqAddr = a; reqMask = m; reqWdata = 16'h5A5A;
    pushRead(a, m);
    @(posedge clk);
    @(negedge clk); #2;
    reqValid = 0;
    drainQ();
  endtask

  // n back-to-back writes at base+k, optional read presented in the last hold
  task automatic wrBurst(int n, logic [15:0] base, logic [15:0] seed,
                         logic [1:0] m, bit thenRd, logic [15:0] ra,
                         logic [1:0] rm);
    int gap = 1;
    for (int k = 0; k < n; k++) begin
      logic [15:0] a, d;
      a = base + 16'(k);
      d = seed ^ (16'h1357 * 16'(k + 1));
      @(negedge clk); #2;
      reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d; reqMask = m;
      if (k == 0)
        for (int i = 0; i < LDC; i++)
          expQ.push_back(mk(0, 1, 1, 2'b11, 0, 0, 0, 1, a, 0, '0, "R4"));
      for (int i = 0; i < PLC; i++)
        expQ.push_back(mk(0, 1, 0, ~m, 1, 0, 0, 1, a, 1, d,
                          (m == 2'b00) ? "R10" : "R5"));
      expQ.push_back(mk(0, 1, 0, 2'b11, 1, 1, 0, 1, a, 1, d, "R7"));
      shadow[a[7:0]] = laneMerge(shadow[a[7:0]], d, m);
      repeat (gap) @(posedge clk);
      gap = (k == 0) ? (LDC + PLC + 1) : (PLC + 1);
    end
    if (thenRd) begin
      @(negedge clk); #2;
      reqValid = 1; reqWrite = 0; reqAddr = ra; reqMask = rm;
      expQ.push_back(mk(0, 1, 1, 2'b11, 0, 0, 0, 1, ra, 0, '0, "R8"));
      pushRead(ra, rm);
      repeat (gap) @(posedge clk);
    end else begin
      expQ.push_back(mk(0, 1, 1, 2'b11, 0, 0, 0, 0, '0, 0, '0, "R8"));
    end
    @(negedge clk); #2;
    reqValid = 0;
    drainQ();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmpPins(idleE(0, "R1"));
    #2 rstN = 1;
    @(negedge clk);
    cmpPins(idleE(0, "R1"));
    monOn = 1;

    wrBurst(1, 16'h0010, 16'hA1B2, 2'b11, 0, '0, '0);   // R5 full word
    readOp(16'h0010, 2'b11);                            // R2 R3
    wrBurst(1, 16'h0010, 16'h3C4D, 2'b01, 0, '0, '0);   // lower lane only
    readOp(16'h0010, 2'b11);
    readOp(16'h0010, 2'b10);                            // R3 lower lane zero
    readOp(16'h0010, 2'b01);                            // R3 upper lane zero
    wrBurst(3, 16'h0020, 16'h0F0F, 2'b11, 1, 16'h0021, 2'b11);  // R7 R8
    wrBurst(2, 16'h0030, 16'hF00D, 2'b10, 1, 16'h0030, 2'b11);
    wrBurst(1, 16'h0010, 16'hFFFF, 2'b00, 0, '0, '0);   // R10 empty mask
    readOp(16'h0010, 2'b11);                            // R10 unchanged
    readOp(16'h0022, 2'b11);
    readOp(16'h0031, 2'b11);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule